// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the digital controller in front of an analog-to-digital converter core. Software programs it through one 16-bit control word that holds an end-of-conversion interrupt enable, a start bit that also reads as busy, a select between interrupt and DMA routing, an external trigger enable, a sequencing mode and a first/last channel range. Once started, the block walks the selected channels in ascending order. For each channel it raises a conversion request with a channel index and waits for the converter's done pulse before it moves on.

The converter returns a data word with each done pulse. The block keeps the latest word per channel in a small capture store that can be read by channel index. At the end of a pass it emits a one-cycle end-of-conversion pulse, either on the interrupt output or on the DMA request output. In the one-channel and one-pass modes the start bit then clears itself. In the loop mode the walk restarts until software writes the start bit to 0 or the standby input aborts it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, no conversion request is raised, both event outputs are low and every capture slot reads 0.
- R2: The start bit (bit 13) reads 1 from the cycle after a sequence starts until the cycle after it ends, and the conversion request is only high while it reads 1.
- R3: Mode 00 (bits 9:8) converts only the channel in the first-channel field (bits 3:0); the start bit then clears itself and the last-channel field is not used.
- R4: Mode 01 converts each channel from first up to last once, in ascending order, with one request per channel, waiting for that channel's done pulse before moving on. If last is below first, only the first channel is converted. The start bit then clears itself.
- R5: Modes 10 and 11 repeat the first-to-last walk without stopping. Writing 0 to the start bit ends a sequence in any mode within one clock, without an end-of-conversion pulse.
- R6: A write made while the start bit is 1 does not change the interrupt enable (bit 14), the DMA select (bit 12), the mode or the channel fields. The trigger enable (bit 11) can be written at any time.
- R7: At the end of a pass, DMA select 1 pulses dma_req and never irq. DMA select 0 with interrupt enable 1 pulses irq. DMA select 0 with interrupt enable 0 pulses neither.
- R8: The end-of-conversion pulse lasts one cycle and is high in the cycle after the done pulse that completes a pass. In the loop modes it fires once per pass.
- R9: A high standby input clears the start bit and the request at the next clock edge, with no end-of-conversion pulse. Start writes and triggers are ignored while standby is high.
- R10: With the trigger enable at 1 and the block idle, a one-cycle trig pulse starts a sequence with the stored settings. A trig pulse is ignored when the trigger enable is 0 or when a sequence is already running.
- R11: The data word that arrives with each accepted done pulse is stored in the slot of the requested channel, and rd_data shows the slot selected by rd_ch.
- R12: The channel fields hold only log2(N_CH) low bits. Bits 15 and 10 read 0, and the read layout is [14] interrupt enable, [13] start, [12] DMA select, [11] trigger enable, [9:8] mode, [7:4] last, [3:0] first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data, start bit shows busy |
| trig | input | 1 | External timer trigger pulse |
| standby | input | 1 | Standby entry, aborts any sequence |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | log2(N_CH) | Channel index of the request |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | DATA_W | Converter result, valid with conv_done |
| rd_ch | input | log2(N_CH) | Capture slot select |
| rd_data | output | DATA_W | Captured result of the selected slot |
| irq | output | 1 | End-of-conversion interrupt pulse |
| dma_req | output | 1 | End-of-conversion DMA request pulse |

## Verification
A wrong channel counter shows at the ports as soon as the next request is raised: conv_ch leaves the programmed range, or the order of channels handed to the converter differs from the expected walk. A wrong busy or mode state shows within one cycle after the final done pulse: the start bit stays set in a one-shot mode, clears in loop mode, or the event comes out on the wrong output. A corrupted held field is seen directly on the read data, and it also shows in the routing at the end of the pass.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// adc_seq_pkg: shared control-word layout, mode encoding and the stored
// configuration type of the conversion sequencer. Assumes a 16-bit control word.
package adc_seq_pkg;

    localparam int unsigned CW_W      = 16;
    localparam int unsigned B_IE      = 14;
    localparam int unsigned B_GO      = 13;
    localparam int unsigned B_DSEL    = 12;
    localparam int unsigned B_TEN     = 11;
    localparam int unsigned MODE_LSB  = 8;
    localparam int unsigned LAST_LSB  = 4;
    localparam int unsigned FIRST_LSB = 0;

    typedef enum logic [1:0] {
        MODE_ONE   = 2'b00,
        MODE_PASS  = 2'b01,
        MODE_LOOP  = 2'b10,
        MODE_LOOPB = 2'b11
    } seq_mode_e;

    typedef struct packed {
        logic      ie;
        logic      dsel;
        logic      ten;
        seq_mode_e mode;
        logic [3:0] last;
        logic [3:0] first;
    } seq_cfg_t;

    function automatic logic is_loop(seq_mode_e m);
        return (m == MODE_LOOP) || (m == MODE_LOOPB);
    endfunction

endpackage

// File: rtl/adc_ctrl_reg.sv
`timescale 1ns/1ps
// adc_ctrl_reg: holds the programmable fields of the control word.
// Routing, mode and channel fields only accept writes while idle; the
// trigger enable accepts writes at any time. Channel fields are masked
// to the implemented index width. Assumes N_CH is a power of two, 2..16.
module adc_ctrl_reg
    import adc_seq_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [CW_W-1:0] wdata,
    input  logic            busy,
    output seq_cfg_t        cfg_q,
    output seq_cfg_t        cfg_nx
);
    localparam logic [3:0] CH_MASK = 4'(N_CH - 1);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[15], wdata[B_GO], wdata[10]};

    // next configuration: trigger enable always, the rest only while idle
    always_comb begin
        cfg_nx = cfg_q;
        if (wr) begin
            cfg_nx.ten = wdata[B_TEN];
            if (!busy) begin
                cfg_nx.ie    = wdata[B_IE];
                cfg_nx.dsel  = wdata[B_DSEL];
                cfg_nx.mode  = seq_mode_e'(wdata[MODE_LSB +: 2]);
                cfg_nx.last  = wdata[LAST_LSB +: 4] & CH_MASK;
                cfg_nx.first = wdata[FIRST_LSB +: 4] & CH_MASK;
            end
        end
    end

    // configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_nx;
    end
endmodule

// File: rtl/adc_chan_walker.sv
`timescale 1ns/1ps
// adc_chan_walker: owns the start/busy bit and walks the channel range.
// One request per channel; the request drops for one cycle after each
// accepted done pulse. Stop (software or standby) wins over a done in the
// same cycle. Assumes the mode and range inputs are stable while busy.
module adc_chan_walker
    import adc_seq_pkg::*;
#(
    parameter  int N_CH = 8,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            wr_go,
    input  logic            trig,
    input  logic            ten_q,
    input  logic            standby,
    input  seq_mode_e       mode,
    input  logic [3:0]      first_f,
    input  logic [3:0]      last_f,
    input  logic            conv_done,
    output logic            busy,
    output logic            conv_req,
    output logic [CH_W-1:0] cur_ch,
    output logic            step,
    output logic            pass_done
);
    logic [CH_W-1:0] first_c, last_c, end_c;
    logic            start_hit, stop_hit;

    // start, stop and step decode for this cycle
    always_comb begin
        first_c   = CH_W'(first_f);
        last_c    = CH_W'(last_f);
        end_c     = ((mode == MODE_ONE) || (last_c < first_c)) ? first_c : last_c;
        start_hit = !busy && !standby && ((wr && wr_go) || (trig && ten_q));
        stop_hit  = busy && (standby || (wr && !wr_go));
        step      = conv_req && conv_done && !stop_hit;
        pass_done = step && (cur_ch == end_c);
    end

    // busy, request and channel state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            conv_req <= 1'b0;
            cur_ch   <= '0;
        end else if (stop_hit) begin
            busy     <= 1'b0;
            conv_req <= 1'b0;
        end else if (start_hit) begin
            busy     <= 1'b1;
            conv_req <= 1'b1;
            cur_ch   <= first_c;
        end else if (pass_done) begin
            conv_req <= 1'b0;
            if (is_loop(mode)) cur_ch <= first_c;
            else               busy   <= 1'b0;
        end else if (step) begin
            conv_req <= 1'b0;
            cur_ch   <= cur_ch + 1'b1;
        end else if (busy && !conv_req) begin
            conv_req <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_eoc_router.sv
`timescale 1ns/1ps
// adc_eoc_router: turns a completed pass into a one-cycle pulse on either
// the DMA request or, if enabled, the interrupt output. Assumes the routing
// bits are held stable while a sequence runs.
module adc_eoc_router (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_done,
    input  logic ie,
    input  logic dsel,
    output logic irq,
    output logic dma_req
);
    // registered event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            dma_req <= 1'b0;
        end else begin
            irq     <= pass_done && !dsel && ie;
            dma_req <= pass_done && dsel;
        end
    end
endmodule

// File: rtl/adc_result_store.sv
`timescale 1ns/1ps
// adc_result_store: one capture slot per channel, written on each accepted
// done pulse, read combinationally by channel index.
module adc_result_store #(
    parameter  int N_CH   = 8,
    parameter  int DATA_W = 10,
    localparam int CH_W   = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [CH_W-1:0]   cap_ch,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [N_CH];

    for (genvar g = 0; g < N_CH; g++) begin : g_slot
        // capture into this slot when its channel completes
        always_ff @(posedge clk) begin
            if (!rst_n)                               slot[g] <= '0;
            else if (cap_en && (cap_ch == CH_W'(g)))  slot[g] <= cap_data;
        end
    end

    assign rd_data = slot[rd_ch];
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// adc_seq_ctrl: conversion control sequencer top. Combines the control
// word storage, the channel walker, the end-of-conversion router and the
// capture store. Assumes N_CH is a power of two between 2 and 16.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter  int N_CH   = 8,
    parameter  int DATA_W = 10,
    localparam int CH_W   = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              trig,
    input  logic              standby,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              dma_req
);
    seq_cfg_t cfg_q, cfg_nx;
    logic     busy, step, pass_done;
    logic     unused_nx;

    assign unused_nx = ^{cfg_nx.ie, cfg_nx.dsel, cfg_nx.ten};

    adc_ctrl_reg #(.N_CH(N_CH)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .busy   (busy),
        .cfg_q  (cfg_q),
        .cfg_nx (cfg_nx)
    );

    adc_chan_walker #(.N_CH(N_CH)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wr_go     (reg_wdata[B_GO]),
        .trig      (trig),
        .ten_q     (cfg_q.ten),
        .standby   (standby),
        .mode      (cfg_nx.mode),
        .first_f   (cfg_nx.first),
        .last_f    (cfg_nx.last),
        .conv_done (conv_done),
        .busy      (busy),
        .conv_req  (conv_req),
        .cur_ch    (conv_ch),
        .step      (step),
        .pass_done (pass_done)
    );

    adc_eoc_router u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_done (pass_done),
        .ie        (cfg_q.ie),
        .dsel      (cfg_q.dsel),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    adc_result_store #(.N_CH(N_CH), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (step),
        .cap_ch   (conv_ch),
        .cap_data (conv_data),
        .rd_ch    (rd_ch),
        .rd_data  (rd_data)
    );

    assign reg_rdata = {1'b0, cfg_q.ie, busy, cfg_q.dsel, cfg_q.ten, 1'b0,
                        cfg_q.mode, cfg_q.last, cfg_q.first};
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
// adc_seq_ctrl_chk: port-level properties of the sequencer, bound to the top.
module adc_seq_ctrl_chk #(
    parameter  int N_CH = 8,
    localparam int CH_W = $clog2(N_CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [15:0]     reg_rdata,
    input logic            standby,
    input logic            conv_req,
    input logic [CH_W-1:0] conv_ch,
    input logic            conv_done,
    input logic            irq,
    input logic            dma_req
);
    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> reg_rdata[13]); // R2

    AST_STANDBY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!conv_req && !reg_rdata[13])); // R9

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req)); // R7

    AST_EVENT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || dma_req) |-> $past(conv_done && conv_req)); // R8

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[13] && $past(reg_rdata[13])) |->
        ($stable(reg_rdata[14]) && $stable(reg_rdata[12]) && $stable(reg_rdata[9:0]))); // R6

    AST_CH_NOT_BELOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (int'(conv_ch) >= int'(reg_rdata[3:0]))); // R4
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .standby   (standby),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .conv_done (conv_done),
    .irq       (irq),
    .dma_req   (dma_req)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
    localparam int N_CH = 8;
    localparam int DW   = 10;
    localparam int CW   = $clog2(N_CH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          trig = 1'b0;
    logic          standby = 1'b0;
    logic          conv_req;
    logic [CW-1:0] conv_ch;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic [CW-1:0] rd_ch = '0;
    logic [DW-1:0] rd_data;
    logic          irq, dma_req;

    adc_seq_ctrl #(.N_CH(N_CH), .DATA_W(DW)) u0 (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int lat = 1, cnt = 0, seqn = 0;
    int ev_irq = 0, ev_dma = 0;
    bit prev_irq = 0, prev_dma = 0;
    int obs_ch[$];
    logic [DW-1:0] exp_mem [N_CH];

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // converter model and event monitor, all on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if ((irq || dma_req) && !conv_done)
                chk(0, "R8", "event without preceding done", 1, 0);
            if ((irq && prev_irq) || (dma_req && prev_dma))
                chk(0, "R8", "event longer than one cycle", 2, 1);
            if (irq) ev_irq++;
            if (dma_req) ev_dma++;
            prev_irq = irq;
            prev_dma = dma_req;
        end
        if (conv_done || !conv_req) begin
            conv_done = 1'b0;
            cnt = 0;
        end else if (cnt >= lat) begin
            seqn++;
            conv_done = 1'b1;
            conv_data = DW'((int'(conv_ch) * 37 + seqn * 11) % 1024);
            exp_mem[conv_ch] = conv_data;
            obs_ch.push_back(int'(conv_ch));
        end else begin
            cnt++;
        end
    end

    function automatic logic [15:0] word(bit ie, bit go, bit ds, bit ten, int mode, int last, int first);
        return {1'b0, ie, go, ds, ten, 1'b0, 2'(mode), 4'(last), 4'(first)};
    endfunction

    function automatic int end_of(int mode, int first, int last);
        return (mode == 0 || last < first) ? first : last;
    endfunction

    task automatic wr(input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && reg_rdata[13]; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // one-shot run with the expected channel walk and routing checked
    task automatic run_once(input int mode, input int f, input int l, input bit ie, input bit ds, input int lt, input string rq);
        int si, sd, e, bad;
        lat = lt; obs_ch.delete(); si = ev_irq; sd = ev_dma;
        wr(word(ie, 1, ds, 0, mode, l, f));
        chk(reg_rdata[13] == 1'b1, "R2", "start bit busy after start", reg_rdata[13], 1);
        wait_idle();
        chk(reg_rdata[13] == 1'b0, rq, "start bit self-clears", reg_rdata[13], 0);
        e = end_of(mode, f, l);
        bad = (obs_ch.size() != e - f + 1);
        for (int k = 0; k < obs_ch.size() && !bad; k++) if (obs_ch[k] != f + k) bad = 1;
        chk(!bad, rq, "channel walk count", obs_ch.size(), e - f + 1);
        chk(ev_irq - si == ((!ds && ie) ? 1 : 0), "R7", "irq pulses", ev_irq - si, (!ds && ie) ? 1 : 0);
        chk(ev_dma - sd == (ds ? 1 : 0), "R7", "dma pulses", ev_dma - sd, ds ? 1 : 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 16'h0000, "R1", "control word after reset", reg_rdata, 0);
        chk(!conv_req && !irq && !dma_req, "R1", "outputs idle after reset", {conv_req, irq, dma_req}, 0);
        chk(rd_data == '0, "R1", "capture slot after reset", rd_data, 0);

        // R12 layout and channel masking (no start)
        wr(16'h5BFF);
        chk(reg_rdata == 16'h5B77, "R12", "readback layout", reg_rdata, 16'h5B77);
        wr(16'h0000);

        // R3 single channel, last ignored
        run_once(0, 3, 6, 1, 0, 2, "R3");
        // R4 last below first
        run_once(1, 5, 2, 1, 0, 1, "R4");
        // R4 full range, then R11 capture readback
        run_once(1, 0, 7, 0, 1, 3, "R4");
        for (int c = 0; c < N_CH; c++) begin
            rd_ch = CW'(c); #1;
            chk(rd_data == exp_mem[c], "R11", "captured data", rd_data, exp_mem[c]);
        end
        // R7 neither output when both disabled
        run_once(1, 1, 3, 0, 0, 1, "R7");

        // random one-shot runs
        for (int it = 0; it < 16; it++) begin
            int m, f, l;
            m = $urandom % 2; f = $urandom % N_CH; l = $urandom % N_CH;
            run_once(m, f, l, 1'($urandom), 1'($urandom), 1 + $urandom % 4, m == 0 ? "R3" : "R4");
        end

        // R5 loop mode: three passes, then software stop
        begin
            int si, bad, base;
            lat = 2; obs_ch.delete(); si = ev_irq;
            wr(word(1, 1, 0, 0, 2, 4, 2));
            for (int i = 0; i < 300 && ev_irq - si < 3; i++) @(negedge clk);
            chk(reg_rdata[13] == 1'b1, "R5", "still busy after passes", reg_rdata[13], 1);
            bad = (obs_ch.size() < 9);
            for (int k = 0; k < 9 && !bad; k++) if (obs_ch[k] != 2 + (k % 3)) bad = 1;
            chk(!bad, "R5", "repeated walk order", obs_ch.size(), 9);
            chk(ev_irq - si == 3, "R8", "one pulse per pass", ev_irq - si, 3);
            wr(word(1, 0, 0, 0, 2, 4, 2));
            chk(!reg_rdata[13] && !conv_req, "R5", "stop clears busy and request", {reg_rdata[13], conv_req}, 0);
            base = ev_irq + ev_dma;
            repeat (20) @(negedge clk);
            chk(ev_irq + ev_dma == base, "R5", "no event after stop", ev_irq + ev_dma - base, 0);
        end

        // R6 fields held while busy, trigger enable updates
        begin
            int si, sd;
            lat = 3; si = ev_irq; sd = ev_dma;
            wr(word(1, 1, 0, 0, 1, 7, 0));
            wr(word(0, 1, 1, 1, 0, 5, 5));
            chk(reg_rdata == 16'h6970, "R6", "held fields, new trigger enable", reg_rdata, 16'h6970);
            wait_idle();
            chk(ev_irq - si == 1 && ev_dma == sd, "R6", "routing kept from start", ev_irq - si, 1);
        end

        // R9 standby abort and blocked start
        begin
            int base;
            lat = 5;
            wr(word(1, 1, 0, 1, 1, 7, 0));
            repeat (3) @(negedge clk);
            standby = 1'b1;
            @(negedge clk);
            chk(!reg_rdata[13] && !conv_req, "R9", "standby abort", {reg_rdata[13], conv_req}, 0);
            base = ev_irq + ev_dma;
            wr(word(1, 1, 0, 1, 1, 7, 0));
            chk(!reg_rdata[13], "R9", "start ignored in standby", reg_rdata[13], 0);
            standby = 1'b0;
            repeat (20) @(negedge clk);
            chk(ev_irq + ev_dma == base, "R9", "no event after abort", ev_irq + ev_dma - base, 0);
        end

        // R10 trigger start, trigger while busy, trigger disabled
        begin
            int si;
            lat = 2; obs_ch.delete(); si = ev_irq;
            wr(word(1, 0, 0, 1, 1, 2, 1));
            trig = 1'b1; @(negedge clk); trig = 1'b0;
            chk(reg_rdata[13] == 1'b1, "R10", "trigger starts", reg_rdata[13], 1);
            @(negedge clk);
            trig = 1'b1; @(negedge clk); trig = 1'b0;
            wait_idle();
            chk(obs_ch.size() == 2, "R10", "trigger while busy ignored", obs_ch.size(), 2);
            chk(ev_irq - si == 1, "R10", "one pass from trigger", ev_irq - si, 1);
            wr(word(1, 0, 0, 0, 1, 2, 1));
            trig = 1'b1; @(negedge clk); trig = 1'b0;
            chk(reg_rdata[13] == 1'b0, "R10", "trigger disabled ignored", reg_rdata[13], 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule